// File: doc/BRIEF.md
# Read-Snooping Data Termination Controller

This block sits beside the data pins of a DRAM device and decides when the on-die data-line terminators are switched on. It watches the shared command bus. Whenever a read command appears on the row-strobe, column-strobe and write-enable pins, it schedules a period during which the data termination enable is pulled low. A reading controller needs the bus unterminated at the far end. Chip select plays no part in this decision. A read aimed at the other rank of a two-rank board therefore switches off this device's data terminators just as a read to this device does.

The position of the disable period follows the programmed CAS latency. The period begins CAS latency minus one clock after the read is sampled and lasts four clocks. The latency is captured when the read is seen, so later reprogramming does not move windows that are already scheduled. When reads follow each other closely, their periods merge into one continuous low stretch. The enable returns high four clocks after the start of the last one. Command and address terminators are not under this block's control.

Top module: `dterm_snoop`

## Requirements
- R1: A read is the pin pattern ras_n=1, cas_n=0, we_n=1 sampled on a rising clock edge. It is recognised whatever the level of cs_n.
- R2: For a read sampled at edge t with latency CL, dte_en is low from edge t+CL-1 onward.
- R3: A lone read keeps dte_en low for exactly 4 cycles: it is low after edges t+CL-1 through t+CL+2 and high again after edge t+CL+3.
- R4: No pattern other than the read pattern ever lowers dte_en, with cs_n at either level. This covers NOP (all three pins high), deselect, activate, write, precharge, refresh, mode-set and burst-stop.
- R5: cas_lat is captured at the edge that samples the read. Changing it afterwards does not move that read's window.
- R6: Every read gets its own window, even when reads arrive on every cycle. Windows that touch or overlap form one continuous low stretch, which ends 4 cycles after the start of the last window.
- R7: A cas_lat value outside CL_MIN..CL_MAX (default 5..15) is treated as the nearest bound.
- R8: A synchronous active-high rst sets dte_en high on the following cycle and discards all scheduled windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low (not used for read detection) |
| ras_n | input | 1 | Row strobe command pin, active low |
| cas_n | input | 1 | Column strobe command pin, active low |
| we_n | input | 1 | Write enable command pin, active low |
| cas_lat | input | CL_W (4) | Programmed CAS latency in clocks |
| dte_en | output | 1 | Data termination enable, high = terminators on |

## Verification
The bench sends a lone read at every legal latency from 5 to 15, which pins down both where the window starts and how long it lasts. Reads with chip select high separate true snooping from decoding that uses chip select. A sweep of every non-read pin pattern, at both chip-select levels, would reveal any false trigger. Read pairs at gaps of one to five cycles, a burst of reads on every cycle at the largest latency, and a long-latency read followed by a short-latency one separate correct merging and slot tracking from dropped or misplaced windows. Out-of-range latencies, and a reset that arrives in the middle of a window, test clamping and the discarding of pending windows.

// File: rtl/dterm_pkg.sv
package dterm_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } bus_cmd_t;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_OPEN   = 3'd3,
        OP_CLOSE  = 3'd4,
        OP_REFR   = 3'd5,
        OP_MODE   = 3'd6,
        OP_STOP   = 3'd7
    } bus_op_e;

    localparam int unsigned WINDOW_LEN = 4;

    // Decode the strobe pins only; chip select is deliberately left out.
    function automatic bus_op_e classify(input bus_cmd_t c);
        unique case ({c.ras_n, c.cas_n, c.we_n})
            3'b111:  return OP_IDLE;
            3'b101:  return OP_READ;
            3'b100:  return OP_WRITE;
            3'b011:  return OP_OPEN;
            3'b010:  return OP_CLOSE;
            3'b001:  return OP_REFR;
            3'b000:  return OP_MODE;
            default: return OP_STOP;
        endcase
    endfunction

    function automatic int unsigned clamp_lat(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/dterm_decode.sv
module dterm_decode
    import dterm_pkg::*;
(
    input  bus_cmd_t cmd_i,
    output bus_op_e  op_o,
    output logic     rd_hit_o
);
    always_comb begin
        op_o     = classify(cmd_i);
        rd_hit_o = (op_o == OP_READ);
    end
endmodule

// File: rtl/dterm_sched.sv
module dterm_sched
    import dterm_pkg::*;
#(
    parameter int unsigned CL_MIN = 5,
    parameter int unsigned CL_MAX = 15,
    parameter int unsigned CL_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_hit_i,
    input  logic [CL_W-1:0] lat_i,
    output logic            start_o
);
    // slot[i] set means a window opens i+1 edges from now
    localparam int unsigned DEPTH = CL_MAX - 1;

    logic [DEPTH-1:0] slot_q;
    logic [DEPTH-1:0] slot_d;
    int unsigned      lat_eff;
    int unsigned      tgt;

    always_comb begin
        lat_eff = clamp_lat(int'(lat_i), CL_MIN, CL_MAX);
        tgt     = lat_eff - 2;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic from_up;
        if (i == DEPTH - 1) begin : g_top
            assign from_up = 1'b0;
        end else begin : g_mid
            assign from_up = slot_q[i+1];
        end
        assign slot_d[i] = from_up | (rd_hit_i && (tgt == i));
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign start_o = slot_q[0];

    // R4: with nothing pending and no read, no window can open next cycle
    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_q == '0 && !rd_hit_i) |=> !start_o);

    // R8: reset empties every pending slot
    p_reset_flush_r8: assert property (@(posedge clk)
        rst |=> (slot_q == '0));
endmodule

// File: rtl/dterm_window.sv
module dterm_window
    import dterm_pkg::*;
#(
    parameter int unsigned WIN = WINDOW_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic dte_o
);
    localparam int unsigned CW = $clog2(WIN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (start_i)       left_q <= CW'(WIN);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign dte_o = (left_q == '0);

    // R2: a window start always pulls the enable low on the next cycle
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !dte_o);

    // R3: once the enable falls it stays low for at least one more cycle
    p_min_low_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dte_o) |=> !dte_o);

    // R3: a fall is always caused by a window start one edge earlier
    p_fall_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dte_o) |-> $past(start_i));
endmodule

// File: rtl/dterm_snoop.sv
module dterm_snoop
    import dterm_pkg::*;
#(
    parameter int unsigned CL_MIN = 5,
    parameter int unsigned CL_MAX = 15,
    parameter int unsigned CL_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [CL_W-1:0] cas_lat,
    output logic            dte_en
);
    bus_cmd_t cmd;
    bus_op_e  op;
    logic     rd_hit;
    logic     win_start;

    assign cmd = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    dterm_decode u_dec (
        .cmd_i    (cmd),
        .op_o     (op),
        .rd_hit_o (rd_hit)
    );

    dterm_sched #(
        .CL_MIN (CL_MIN),
        .CL_MAX (CL_MAX),
        .CL_W   (CL_W)
    ) u_sched (
        .clk      (clk),
        .rst      (rst),
        .rd_hit_i (rd_hit),
        .lat_i    (cas_lat),
        .start_o  (win_start)
    );

    dterm_window #(
        .WIN (WINDOW_LEN)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .start_i (win_start),
        .dte_o   (dte_en)
    );

    // R8: reset returns the enable high on the following cycle
    p_reset_high_r8: assert property (@(posedge clk)
        rst |=> dte_en);

    // R4: a NOP pattern never produces a read hit, whatever chip select does
    p_nop_no_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (ras_n && cas_n && we_n) |-> !rd_hit);
endmodule

// File: tb/dterm_snoop_tb.sv
`timescale 1ns/1ps
module dterm_snoop_tb;
    localparam int CL_MIN = 5;
    localparam int CL_MAX = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [3:0] cas_lat = 4'd5;
    logic       dte_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nrd = 0;
    int rd_t  [1024];
    int rd_cl [1024];
    string tag = "R8";

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dterm_snoop #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .CL_W(4)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cas_lat(cas_lat), .dte_en(dte_en)
    );

    function automatic logic exp_dte(input int e);
        for (int k = 0; k < nrd; k++) begin
            int s;
            s = rd_t[k] + rd_cl[k] - 1;
            if (e >= s && e <= s + 3) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check_now();
        logic e;
        e = exp_dte(cyc);
        checks++;
        if (dte_en !== e) begin
            errors++;
            $display("FAIL %s cycle %0d dte_en=%b expected %b", tag, cyc, dte_en, e);
        end
    endtask

    // sample the previous edge's result, then drive the next command
    task automatic tick(input logic [3:0] c, input int cl);
        @(negedge clk);
        check_now();
        {cs_n, ras_n, cas_n, we_n} = c;
        cas_lat = 4'(cl);
        if (c[2:0] == 3'b101 && !rst && nrd < 1024) begin
            rd_t[nrd]  = cyc + 1;
            rd_cl[nrd] = (cl < CL_MIN) ? CL_MIN : (cl > CL_MAX) ? CL_MAX : cl;
            nrd++;
        end
    endtask

    task automatic idle(input int n, input int cl);
        for (int i = 0; i < n; i++) tick(4'b0111, cl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_now();
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        nrd = 0;
        tag = "R8";
        @(negedge clk);
        check_now();
        rst = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog cycle %0d dte_en=%b expected finish", cyc, dte_en);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        tag = "R8";
        repeat (3) begin @(negedge clk); check_now(); end
        rst = 1'b0;
        idle(3, 5);

        // R2 R3: lone read at every legal latency
        tag = "R2_R3";
        for (int cl = CL_MIN; cl <= CL_MAX; cl++) begin
            tick(4'b0101, cl);
            idle(cl + 6, cl);
        end

        // R1: chip select high still triggers
        tag = "R1";
        tick(4'b1101, 7);
        idle(14, 7);
        tick(4'b1101, 9);
        tick(4'b0101, 9);
        idle(16, 9);

        // R4: every non-read pattern, both chip select levels
        tag = "R4";
        for (int p = 0; p < 16; p++) begin
            if (p[2:0] != 3'b101) tick(4'(p), 5);
        end
        for (int p = 0; p < 16; p++) begin
            if (p[2:0] != 3'b101) tick(4'(p), 5);
        end
        idle(20, 5);

        // R6: pairs at gaps 1..5, then a read every cycle at max latency
        tag = "R6";
        for (int g = 1; g <= 5; g++) begin
            tick(4'b0101, 6);
            idle(g - 1, 6);
            tick(4'b0101, 6);
            idle(14, 6);
        end
        for (int i = 0; i < 10; i++) tick(4'b0101, 15);
        idle(24, 15);
        for (int i = 0; i < 6; i++) begin
            tick(4'b1101, 8);
            idle(5, 8);
        end
        idle(14, 8);

        // R5: latency captured at detection
        tag = "R5";
        tick(4'b0101, 12);
        idle(2, 5);
        tick(4'b0101, 5);
        idle(20, 5);
        tick(4'b0101, 6);
        idle(3, 15);
        idle(14, 15);

        // R7: out-of-range latencies clamp to the minimum
        tag = "R7";
        tick(4'b0101, 0);
        idle(12, 0);
        tick(4'b0101, 3);
        idle(12, 3);

        // R8: reset in the middle of a window and with reads pending
        tag = "R8";
        tick(4'b0101, 5);
        idle(5, 5);
        do_reset();
        idle(12, 5);
        tick(4'b0101, 10);
        idle(3, 10);
        do_reset();
        idle(16, 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule